// File: doc/BRIEF.md
# Secure-Partitioned Backup Register File

This block holds a bank of battery-domain backup words behind a single-cycle request/response port. Every request carries a security attribute. A movable boundary index splits the bank: words with an index below the boundary form the protected group, words at or above it form the open group. Secure requests reach every word and may move the boundary; non-secure requests reach only the open group and can never move the boundary. Requests that are refused return an error flag and no data.

A tamper input wipes the whole bank. The boundary value survives the wipe, so the partition that software set up is still in force after the event. The reset input is the battery-domain power-on reset: it clears the bank and restores the default boundary. A parameter selects whether the wipe follows the tamper level (default) or only its rising edge.

Top module: `secure_backup_bank`

## Requirements
- R1: After reset the boundary reads back as 10, every word reads as zero and no response is pending (`rsp_valid` low).
- R2: A secure read or write may reach any word index 0..31; its response appears with `rsp_valid` high in the cycle after the request, with `rsp_err` low, and a read returns the value last written.
- R3: A non-secure read or write of a word whose index is greater than or equal to the boundary succeeds with `rsp_err` low.
- R4: A non-secure read of a word whose index is below the boundary returns zero data with `rsp_err` high.
- R5: A non-secure write to a word whose index is below the boundary leaves that word unchanged and returns `rsp_err` high.
- R6: When `req_ctrl` is high the request targets the boundary register instead of a word; either security level may read it (value in the low bits of `rsp_rdata`, upper bits zero) and a secure write replaces it.
- R7: A non-secure write to the boundary register leaves it unchanged and returns `rsp_err` high.
- R8: A boundary write value above 32 is stored as 32, which makes every word protected; values 0..32 are stored as given.
- R9: With `tamper` high at a clock edge every word becomes zero at that edge, even if a write to a word is requested in the same cycle; the boundary is not changed by the wipe.
- R10: A granted write returns `rsp_rdata` zero; a cycle without a request yields `rsp_valid` and `rsp_err` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low battery-domain power-on reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure context |
| req_ctrl | input | 1 | 1 = boundary register, 0 = word selected by `req_idx` |
| req_idx | input | 5 | Word index |
| req_wdata | input | 32 | Write data |
| tamper | input | 1 | Tamper detected |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for writes and refused requests |
| rsp_err | output | 1 | Request was refused |

## Verification
The bench walks the boundary through every value from 0 to 35 and an all-ones pattern, and at each setting issues non-secure writes and reads to all 32 words, so an off-by-one comparison at the boundary word, a missing clamp or a wrap of large boundary values shows up as a wrong error flag on one word. A filter that refused correctly but still let the write through would leave changed data that a later secure read exposes. A non-secure attempt to move the boundary is followed by a readback, catching a design that flags the error but stores the value anyway. The tamper case pairs the wipe with a secure write in the same cycle; a design that gave the write priority would leave that word non-zero, and one that wiped the boundary too would read back 10 or 0 instead of the set value.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

   // Outcome of the access filter for one request
   typedef struct packed {
      logic grant;
      logic deny;
   } sbb_verdict_t;

   typedef enum logic {
      SBB_TAMPER_LEVEL = 1'b0,
      SBB_TAMPER_EDGE  = 1'b1
   } sbb_tamper_mode_e;

endpackage

// File: rtl/sbb_boundary.sv
module sbb_boundary #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_REGS    = 32,
   parameter int unsigned RESET_BOUND = 10,
   localparam int unsigned BND_W      = $clog2(NUM_REGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_val,
   output logic [BND_W-1:0]  bound_q
);

   logic [BND_W-1:0] bound_nxt;

   // Anything past the bank size saturates to "all protected"
   always_comb begin
      if (wr_val > DATA_W'(NUM_REGS))
         bound_nxt = BND_W'(NUM_REGS);
      else
         bound_nxt = wr_val[BND_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bound_q <= BND_W'(RESET_BOUND);
      else if (wr_en)
         bound_q <= bound_nxt;
   end

endmodule

// File: rtl/sbb_filter.sv
module sbb_filter
   import sbb_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS),
   localparam int unsigned BND_W   = $clog2(NUM_REGS + 1)
) (
   input  logic             valid,
   input  logic             write,
   input  logic             secure,
   input  logic             ctrl,
   input  logic [IDX_W-1:0] idx,
   input  logic [BND_W-1:0] bound,
   output logic             word_we,
   output logic             bound_we,
   output sbb_verdict_t     verdict
);

   logic [BND_W-1:0] idx_ext;
   logic             in_range;
   logic             word_ok;
   logic             ctrl_ok;

   assign idx_ext  = BND_W'(idx);
   assign in_range = idx_ext < BND_W'(NUM_REGS);
   assign word_ok  = in_range & (secure | (idx_ext >= bound));
   assign ctrl_ok  = secure | ~write;

   always_comb begin
      verdict.grant = ctrl ? ctrl_ok : word_ok;
      verdict.deny  = valid & ~verdict.grant;
   end

   assign word_we  = valid & write & ~ctrl & word_ok;
   assign bound_we = valid & write & ctrl & secure;

endmodule

// File: rtl/sbb_array.sv
module sbb_array #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       erase,
   input  logic                       we,
   input  logic [IDX_W-1:0]           idx,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] bank_flat
);

   logic [DATA_W-1:0] word_q [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      // Erase outranks any write in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[g] <= '0;
         else if (erase)
            word_q[g] <= '0;
         else if (we && (idx == IDX_W'(g)))
            word_q[g] <= wdata;
      end
      assign bank_flat[g*DATA_W +: DATA_W] = word_q[g];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (idx == IDX_W'(i))
            rdata = word_q[i];
   end

endmodule

// File: rtl/secure_backup_bank.sv
module secure_backup_bank
   import sbb_pkg::*;
#(
   parameter int unsigned      DATA_W      = 32,
   parameter int unsigned      NUM_REGS    = 32,
   parameter int unsigned      RESET_BOUND = 10,
   parameter sbb_tamper_mode_e TAMPER_MODE = SBB_TAMPER_LEVEL,
   localparam int unsigned     IDX_W       = $clog2(NUM_REGS),
   localparam int unsigned     BND_W       = $clog2(NUM_REGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_secure,
   input  logic              req_ctrl,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              tamper,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);

   if (NUM_REGS < 2) begin : g_chk_regs
      $error("secure_backup_bank: NUM_REGS must be at least 2");
   end
   if (RESET_BOUND > NUM_REGS) begin : g_chk_bound
      $error("secure_backup_bank: RESET_BOUND exceeds NUM_REGS");
   end
   if (DATA_W < BND_W) begin : g_chk_width
      $error("secure_backup_bank: DATA_W too narrow for the boundary");
   end

   logic [BND_W-1:0]           bound_q;
   logic                       word_we;
   logic                       bound_we;
   sbb_verdict_t               verdict;
   logic                       erase;
   logic [DATA_W-1:0]          word_rd;
   logic [DATA_W-1:0]          rd_mux;
   logic [NUM_REGS*DATA_W-1:0] bank_flat;

   if (TAMPER_MODE == SBB_TAMPER_EDGE) begin : g_tamper_edge
      logic tamper_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tamper_d <= 1'b0;
         else        tamper_d <= tamper;
      end
      assign erase = tamper & ~tamper_d;
   end else begin : g_tamper_level
      assign erase = tamper;
   end

   sbb_boundary #(
      .DATA_W      (DATA_W),
      .NUM_REGS    (NUM_REGS),
      .RESET_BOUND (RESET_BOUND)
   ) u_bound (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bound_we),
      .wr_val  (req_wdata),
      .bound_q (bound_q)
   );

   sbb_filter #(
      .NUM_REGS (NUM_REGS)
   ) u_filter (
      .valid    (req_valid),
      .write    (req_write),
      .secure   (req_secure),
      .ctrl     (req_ctrl),
      .idx      (req_idx),
      .bound    (bound_q),
      .word_we  (word_we),
      .bound_we (bound_we),
      .verdict  (verdict)
   );

   sbb_array #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase     (erase),
      .we        (word_we),
      .idx       (req_idx),
      .wdata     (req_wdata),
      .rdata     (word_rd),
      .bank_flat (bank_flat)
   );

   assign rd_mux = req_ctrl ? DATA_W'(bound_q) : word_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= verdict.deny;
         rsp_rdata <= (req_valid && verdict.grant && !req_write) ? rd_mux : '0;
      end
   end

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32,
   parameter bit          LEVEL    = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS),
   localparam int unsigned BND_W   = $clog2(NUM_REGS + 1)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic                       req_write,
   input logic                       req_secure,
   input logic                       req_ctrl,
   input logic [IDX_W-1:0]           req_idx,
   input logic                       tamper,
   input logic                       rsp_valid,
   input logic [DATA_W-1:0]          rsp_rdata,
   input logic                       rsp_err,
   input logic [BND_W-1:0]           bound_q,
   input logic [NUM_REGS*DATA_W-1:0] bank_flat
);

   logic [BND_W-1:0] idx_ext;
   assign idx_ext = BND_W'(req_idx);

   p_secure_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_secure && (idx_ext < BND_W'(NUM_REGS)))
      |=> (rsp_valid && !rsp_err));

   p_ns_read_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_ctrl && !req_secure && (idx_ext < bound_q))
      |=> (rsp_err && (rsp_rdata == '0)));

   p_ns_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_ctrl && !req_secure && (idx_ext < bound_q) && !tamper)
      |=> (rsp_err && $stable(bank_flat)));

   p_ns_bound_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_ctrl && !req_secure)
      |=> (rsp_err && $stable(bound_q)));

   p_bound_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bound_q <= BND_W'(NUM_REGS));

   p_tamper_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (LEVEL && tamper) |=> (bank_flat == '0));

   p_tamper_keeps_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tamper && !(req_valid && req_write && req_ctrl)) |=> $stable(bound_q));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_err));

endmodule

bind secure_backup_bank sbb_checker #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .LEVEL    (TAMPER_MODE == sbb_pkg::SBB_TAMPER_LEVEL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_secure (req_secure),
   .req_ctrl   (req_ctrl),
   .req_idx    (req_idx),
   .tamper     (tamper),
   .rsp_valid  (rsp_valid),
   .rsp_rdata  (rsp_rdata),
   .rsp_err    (rsp_err),
   .bound_q    (bound_q),
   .bank_flat  (bank_flat)
);

// File: tb/secure_backup_bank_tb.sv
module secure_backup_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NREG       = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_secure = 1'b0;
   logic        req_ctrl = 1'b0;
   logic [4:0]  req_idx = '0;
   logic [31:0] req_wdata = '0;
   logic        tamper = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rsp_err;

   int vecs = 0;
   int errs = 0;
   logic [31:0] mdl [NREG];
   int unsigned bnd_mdl;

   always #(CLK_PERIOD/2) clk = ~clk;

   secure_backup_bank u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_secure (req_secure),
      .req_ctrl   (req_ctrl),
      .req_idx    (req_idx),
      .req_wdata  (req_wdata),
      .tamper     (tamper),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .rsp_err    (rsp_err)
   );

   function automatic logic [31:0] pat(int b, int i);
      return (32'h9E37_79B9 * (b + 1)) ^ (i << 8) ^ i;
   endfunction

   // Called at a negedge; returns at the next negedge with the response visible
   task automatic issue(input bit ctrl, input bit wr, input bit sec,
                        input int idx, input logic [31:0] wd);
      req_valid  = 1'b1;
      req_ctrl   = ctrl;
      req_write  = wr;
      req_secure = sec;
      req_idx    = 5'(idx);
      req_wdata  = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid  = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] exp_d, input logic exp_e);
      vecs++;
      if (rsp_valid !== 1'b1 || rsp_rdata !== exp_d || rsp_err !== exp_e) begin
         errs++;
         $display("FAIL %s: valid %b data %h err %b, expected valid 1 data %h err %b",
                  tag, rsp_valid, rsp_rdata, rsp_err, exp_d, exp_e);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: quiet after reset, default boundary, zero words
      vecs++;
      if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
         errs++;
         $display("FAIL R1 idle: valid %b err %b, expected 0 0", rsp_valid, rsp_err);
      end
      issue(1, 0, 1, 0, '0);
      chk("R1 reset boundary", 32'd10, 1'b0);
      for (int i = 0; i < NREG; i++) begin
         issue(0, 0, 1, i, '0);
         chk("R1 reset word", 32'd0, 1'b0);
      end
      bnd_mdl = 10;

      // R2: secure access to every word
      for (int i = 0; i < NREG; i++) begin
         mdl[i] = pat(99, i);
         issue(0, 1, 1, i, mdl[i]);
         chk("R2/R10 secure write", 32'd0, 1'b0);
      end
      for (int i = 0; i < NREG; i++) begin
         issue(0, 0, 1, i, '0);
         chk("R2 secure read", mdl[i], 1'b0);
      end

      // R3..R6, R8: sweep the boundary, non-secure traffic to every word
      for (int k = 0; k <= 36; k++) begin
         logic [31:0] wv;
         wv = (k == 36) ? 32'hFFFF_FFFF : 32'(k);
         bnd_mdl = (wv > 32'(NREG)) ? NREG : int'(wv);
         issue(1, 1, 1, 0, wv);
         chk("R6 secure boundary write", 32'd0, 1'b0);
         issue(1, 0, 0, 0, '0);
         chk("R6/R8 boundary readback", 32'(bnd_mdl), 1'b0);
         for (int i = 0; i < NREG; i++) begin
            bit prot;
            prot = (i < int'(bnd_mdl));
            issue(0, 1, 0, i, pat(k, i));
            if (!prot) mdl[i] = pat(k, i);
            chk(prot ? "R5 ns write refused" : "R3 ns write", 32'd0, prot);
         end
         for (int i = 0; i < NREG; i++) begin
            bit prot;
            prot = (i < int'(bnd_mdl));
            issue(0, 0, 0, i, '0);
            chk(prot ? "R4 ns read refused" : "R3 ns read", prot ? 32'd0 : mdl[i], prot);
         end
         for (int i = 0; i < NREG; i++) begin
            issue(0, 0, 1, i, '0);
            chk("R5 content after ns writes", mdl[i], 1'b0);
         end
      end

      // R7: non-secure boundary write ignored
      issue(1, 1, 1, 0, 32'd12);
      chk("R6 set boundary 12", 32'd0, 1'b0);
      issue(1, 1, 0, 0, 32'd3);
      chk("R7 ns boundary write", 32'd0, 1'b1);
      issue(1, 0, 1, 0, '0);
      chk("R7 boundary unchanged", 32'd12, 1'b0);
      issue(0, 1, 0, 11, 32'h1234_5678);
      chk("R7 word 11 still protected", 32'd0, 1'b1);

      // R9: tamper with a colliding secure write
      tamper = 1'b1;
      issue(0, 1, 1, 3, 32'hDEAD_BEEF);
      tamper = 1'b0;
      chk("R9 write during tamper", 32'd0, 1'b0);
      for (int i = 0; i < NREG; i++) begin
         issue(0, 0, 1, i, '0);
         chk("R9 word wiped", 32'd0, 1'b0);
      end
      issue(1, 0, 1, 0, '0);
      chk("R9 boundary kept", 32'd12, 1'b0);

      // R10: idle cycle yields no response
      @(negedge clk);
      vecs++;
      if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
         errs++;
         $display("FAIL R10 idle: valid %b err %b, expected 0 0", rsp_valid, rsp_err);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule